// File: doc/BRIEF.md
# Turbo CPU Bus Wait Controller

This block sits between a processor clocked several times faster than a standard expansion bus and that bus. On every I/O cycle and every access to external memory, it stalls the processor through an active-low wait line. It then starts the bus-side strobe only after a bus-clock enable pulse and keeps that strobe low for a fixed number of bus-clock periods. The bus therefore sees cycles of standard length whatever the processor's own speed. Accesses to internal memory are not touched, so instruction fetches from on-chip memory keep the full processor rate.

A second rule protects the video processor. Its four I/O ports start at a configurable base address, 98H by default, and they need a long recovery time between accesses. The block counts bus-clock pulses from the end of one video-port access. The next video-port strobe may start no earlier than `VDP_GAP` pulses later, 27 by default. Other I/O ports ignore this spacing.

The bus-clock enable is a one-fast-clock-wide pulse, one per bus period, produced outside this block in the fast clock domain. Every output changes on the fast clock. The only exception is the wait line, which also reacts within the same cycle to a new request from the processor.

Top module: `turbo_bus_wait`

## Requirements
- R1: After reset, with no request pending, `cpu_wait_n`, `ext_iorq_n`, `ext_mreq_n`, `ext_rd_n` and `ext_wr_n` are all high.
- R2: A memory access with `mem_internal` = 1 never pulls `cpu_wait_n` low and never asserts any bus-side strobe.
- R3: An I/O request (`cpu_iorq_n` = 0 with `cpu_m1_n` = 1) or an external memory request (`cpu_mreq_n` = 0 with `mem_internal` = 0) drives `cpu_wait_n` low in the same fast-clock cycle in which it first appears.
- R4: A bus-side strobe goes low only in the fast-clock cycle that follows a clock edge at which `bus_ce` was 1. A request first seen in a cycle is never started at that cycle's own edge.
- R5: `ext_iorq_n` stays low across exactly `IO_BUS_CYCLES` (default 3) `bus_ce` pulses. It rises in the cycle after the last of them.
- R6: `ext_mreq_n` for an external memory access stays low across exactly `MEM_BUS_CYCLES` (default 2) `bus_ce` pulses.
- R7: `cpu_wait_n` returns high in the same cycle in which the bus-side strobe is released. It then stays high until the processor ends its cycle.
- R8: A video-port access is an I/O access to an address from `VDP_BASE` (98H) through `VDP_BASE+VDP_PORTS-1` (9BH). Such an access starts at the earliest on the `VDP_GAP`-th `bus_ce` pulse after the pulse that ended the previous video-port access. When the processor issues it back-to-back, it starts on exactly that pulse.
- R9: An I/O access outside the video window (97H, 9CH) starts on the first usable `bus_ce` pulse, even right after a video-port access.
- R10: An interrupt-acknowledge cycle (`cpu_iorq_n` = 0 with `cpu_m1_n` = 0) gets no wait and no bus strobe.
- R11: The spacing count saturates. The first video-port access after reset, or after an idle time longer than the gap, starts within two `bus_ce` pulses of the request.
- R12: While a bus strobe is low, `ext_rd_n` is low for a read and `ext_wr_n` is low for a write. The direction is the one captured when the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce | input | 1 | One-cycle pulse marking each bus-clock period |
| cpu_iorq_n | input | 1 | Processor I/O request, active low |
| cpu_mreq_n | input | 1 | Processor memory request, active low |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_m1_n | input | 1 | Processor opcode-fetch / acknowledge marker, active low |
| cpu_addr_lo | input | 8 | Low address byte (I/O port number) |
| mem_internal | input | 1 | 1 when the memory access targets internal memory |
| cpu_wait_n | output | 1 | Wait request back to the processor, active low |
| ext_iorq_n | output | 1 | Aligned and stretched bus I/O strobe |
| ext_mreq_n | output | 1 | Aligned and stretched bus memory strobe |
| ext_rd_n | output | 1 | Bus read strobe |
| ext_wr_n | output | 1 | Bus write strobe |

## Verification
The hardest case to reach is a video-port access that arrives while the spacing count is still running, right at the edge of the window. The stimulus covers it by issuing 98H and 9BH accesses back-to-back, so each one waits out the full gap and must start on exactly the 27th pulse. It then places 9CH and 97H directly after a video access, where they must not wait. Idle stretches of varying length between accesses move the request against the bus-clock phase, which exercises every alignment offset. A long pause before a final video access shows that the saturated count lets it through without delay.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef enum logic {
    ACC_MEM = 1'b0,
    ACC_IO  = 1'b1
  } acc_kind_e;

  // true when a port number falls in the video processor window
  function automatic logic in_video_window(input logic [7:0] port,
                                           input logic [7:0] base,
                                           input int unsigned count);
    int unsigned p, b;
    p = 32'(port);
    b = 32'(base);
    return (p >= b) && (p < b + count);
  endfunction

  // bus-clock periods a strobe of the given kind stays low
  function automatic int unsigned hold_len(input acc_kind_e kind,
                                           input int unsigned io_len,
                                           input int unsigned mem_len);
    return (kind == ACC_IO) ? io_len : mem_len;
  endfunction

endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
  import bwc_pkg::*;
#(
  parameter logic [7:0]  VDP_BASE  = 8'h98,
  parameter int unsigned VDP_PORTS = 4
) (
  input  logic       iorq_n,
  input  logic       mreq_n,
  input  logic       m1_n,
  input  logic       mem_internal,
  input  logic [7:0] addr,
  output logic       req,
  output acc_kind_e  kind,
  output logic       vdp
);

  logic io_hit, mem_hit;

  assign io_hit  = !iorq_n && m1_n;
  assign mem_hit = !mreq_n && !mem_internal;
  assign req     = io_hit || mem_hit;
  assign kind    = io_hit ? ACC_IO : ACC_MEM;
  assign vdp     = io_hit && in_video_window(addr, VDP_BASE, VDP_PORTS);

endmodule

// File: rtl/bwc_gap_timer.sv
module bwc_gap_timer #(
  parameter int unsigned GAP = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic gap_ok
);

  localparam int unsigned W = $clog2(GAP + 1);

  logic [W-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= W'(GAP);
    end else if (clear) begin
      since <= '0;
    end else if (tick && (since != W'(GAP))) begin
      since <= since + 1'b1;
    end
  end

  // the pulse that sees GAP-1 is the GAP-th pulse after the clearing one
  assign gap_ok = (32'(since) + 1 >= GAP);

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
#(
  parameter int unsigned IO_LEN  = 3,
  parameter int unsigned MEM_LEN = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_ce,
  input  logic      req,
  input  acc_kind_e kind,
  input  logic      vdp,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      gap_ok,
  output logic      wait_n,
  output logic      ext_iorq_n,
  output logic      ext_mreq_n,
  output logic      ext_rd_n,
  output logic      ext_wr_n,
  output logic      start_evt,
  output logic      end_evt,
  output logic      vdp_q
);

  localparam int unsigned LONGEST = (IO_LEN > MEM_LEN) ? IO_LEN : MEM_LEN;
  localparam int unsigned LW      = $clog2(LONGEST + 1);

  seq_state_e   st, st_nx;
  acc_kind_e    kind_q;
  logic         rd_q, wr_q;
  logic [LW-1:0] beats;
  logic [LW-1:0] last_beat;
  logic          holding;

  assign last_beat = LW'(hold_len(kind_q, IO_LEN, MEM_LEN) - 1);
  assign holding   = (st == ST_HOLD);
  assign start_evt = (st == ST_ALIGN) && bus_ce && (!vdp_q || gap_ok);
  assign end_evt   = holding && bus_ce && (beats == last_beat);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (req)       st_nx = ST_ALIGN;
      ST_ALIGN: if (start_evt) st_nx = ST_HOLD;
      ST_HOLD:  if (end_evt)   st_nx = ST_DONE;
      ST_DONE:  if (!req)      st_nx = ST_IDLE;
      default:                 st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind_q <= ACC_MEM;
      vdp_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      beats  <= '0;
    end else begin
      st <= st_nx;
      if ((st == ST_IDLE) && req) begin
        kind_q <= kind;
        vdp_q  <= vdp;
        rd_q   <= !rd_n;
        wr_q   <= !wr_n;
      end
      if (start_evt) begin
        beats <= '0;
      end else if (holding && bus_ce) begin
        beats <= beats + 1'b1;
      end
    end
  end

  assign wait_n     = !(((st == ST_IDLE) && req) || (st == ST_ALIGN) || holding);
  assign ext_iorq_n = !(holding && (kind_q == ACC_IO));
  assign ext_mreq_n = !(holding && (kind_q == ACC_MEM));
  assign ext_rd_n   = !(holding && rd_q);
  assign ext_wr_n   = !(holding && wr_q);

endmodule

// File: rtl/turbo_bus_wait.sv
module turbo_bus_wait
  import bwc_pkg::*;
#(
  parameter int unsigned IO_BUS_CYCLES  = 3,
  parameter int unsigned MEM_BUS_CYCLES = 2,
  parameter int unsigned VDP_GAP        = 27,
  parameter logic [7:0]  VDP_BASE       = 8'h98,
  parameter int unsigned VDP_PORTS      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_ce,
  input  logic       cpu_iorq_n,
  input  logic       cpu_mreq_n,
  input  logic       cpu_rd_n,
  input  logic       cpu_wr_n,
  input  logic       cpu_m1_n,
  input  logic [7:0] cpu_addr_lo,
  input  logic       mem_internal,
  output logic       cpu_wait_n,
  output logic       ext_iorq_n,
  output logic       ext_mreq_n,
  output logic       ext_rd_n,
  output logic       ext_wr_n
);

  logic      req, vdp, gap_ok;
  acc_kind_e kind;
  logic      start_evt, end_evt, vdp_q;
  logic      start_vdp, end_vdp;

  assign start_vdp = start_evt && vdp_q;
  assign end_vdp   = end_evt && vdp_q;

  bwc_decode #(
    .VDP_BASE (VDP_BASE),
    .VDP_PORTS(VDP_PORTS)
  ) u_decode (
    .iorq_n      (cpu_iorq_n),
    .mreq_n      (cpu_mreq_n),
    .m1_n        (cpu_m1_n),
    .mem_internal(mem_internal),
    .addr        (cpu_addr_lo),
    .req         (req),
    .kind        (kind),
    .vdp         (vdp)
  );

  bwc_gap_timer #(
    .GAP(VDP_GAP)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bus_ce),
    .clear (end_vdp),
    .gap_ok(gap_ok)
  );

  bwc_seq #(
    .IO_LEN (IO_BUS_CYCLES),
    .MEM_LEN(MEM_BUS_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ce    (bus_ce),
    .req       (req),
    .kind      (kind),
    .vdp       (vdp),
    .rd_n      (cpu_rd_n),
    .wr_n      (cpu_wr_n),
    .gap_ok    (gap_ok),
    .wait_n    (cpu_wait_n),
    .ext_iorq_n(ext_iorq_n),
    .ext_mreq_n(ext_mreq_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .start_evt (start_evt),
    .end_evt   (end_evt),
    .vdp_q     (vdp_q)
  );

endmodule

// File: rtl/turbo_bus_wait_chk.sv
module turbo_bus_wait_chk #(
  parameter int unsigned VDP_GAP = 27
) (
  input logic clk,
  input logic rst_n,
  input logic bus_ce,
  input logic cpu_iorq_n,
  input logic cpu_mreq_n,
  input logic cpu_m1_n,
  input logic mem_internal,
  input logic cpu_wait_n,
  input logic ext_iorq_n,
  input logic ext_mreq_n,
  input logic ext_rd_n,
  input logic ext_wr_n,
  input logic start_vdp,
  input logic end_vdp
);

  localparam int unsigned W = $clog2(VDP_GAP + 1);

  logic [W-1:0] pulses_since;
  logic         bus_idle;

  assign bus_idle = ext_iorq_n && ext_mreq_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulses_since <= W'(VDP_GAP);
    end else if (end_vdp) begin
      pulses_since <= '0;
    end else if (bus_ce && (pulses_since != W'(VDP_GAP))) begin
      pulses_since <= pulses_since + 1'b1;
    end
  end

  assert_internal_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_mreq_n) && mem_internal && cpu_iorq_n) |-> cpu_wait_n);

  assert_wait_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_iorq_n) && cpu_m1_n) |-> !cpu_wait_n);

  assert_strobe_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_idle) |-> $past(bus_ce));

  assert_strobe_end_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(bus_ce));

  assert_release_with_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait_n) |-> bus_idle);

  assert_vdp_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_vdp |-> (32'(pulses_since) + 1 >= VDP_GAP));

  assert_intack_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_iorq_n && !cpu_m1_n) |-> (cpu_wait_n && ext_iorq_n));

  assert_dir_inside_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !bus_idle);

endmodule

bind turbo_bus_wait turbo_bus_wait_chk #(
  .VDP_GAP(VDP_GAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ce      (bus_ce),
  .cpu_iorq_n  (cpu_iorq_n),
  .cpu_mreq_n  (cpu_mreq_n),
  .cpu_m1_n    (cpu_m1_n),
  .mem_internal(mem_internal),
  .cpu_wait_n  (cpu_wait_n),
  .ext_iorq_n  (ext_iorq_n),
  .ext_mreq_n  (ext_mreq_n),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .start_vdp   (start_vdp),
  .end_vdp     (end_vdp)
);

// File: tb/turbo_bus_wait_tb.sv
module turbo_bus_wait_tb;

  localparam int RATIO = 4;
  localparam int IO_W  = 3;
  localparam int MEM_W = 2;
  localparam int GAP   = 27;

  localparam int K_IO    = 0;
  localparam int K_XMEM  = 1;
  localparam int K_IMEM  = 2;
  localparam int K_INTAK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 1'b0;
  logic cpu_iorq_n = 1'b1, cpu_mreq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic cpu_m1_n = 1'b1, mem_internal = 1'b0;
  logic [7:0] cpu_addr_lo = 8'h00;
  logic cpu_wait_n, ext_iorq_n, ext_mreq_n, ext_rd_n, ext_wr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  turbo_bus_wait u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce),
    .cpu_iorq_n(cpu_iorq_n), .cpu_mreq_n(cpu_mreq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n),
    .cpu_addr_lo(cpu_addr_lo), .mem_internal(mem_internal),
    .cpu_wait_n(cpu_wait_n), .ext_iorq_n(ext_iorq_n), .ext_mreq_n(ext_mreq_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus clock: one pulse every RATIO fast cycles, changed after the edge
  int div = 0;
  always @(posedge clk) begin
    #2;
    bus_ce <= (div == RATIO - 1);
    div    <= (div == RATIO - 1) ? 0 : div + 1;
  end

  // ---------------- reference model ----------------
  function automatic bit is_video(input logic [7:0] a);
    return (a == 8'h98) || (a == 8'h99) || (a == 8'h9A) || (a == 8'h9B);
  endfunction

  function automatic bit io_now();
    return !cpu_iorq_n && cpu_m1_n;
  endfunction

  function automatic bit want_bus();
    return io_now() || (!cpu_mreq_n && !mem_internal);
  endfunction

  int m_st = 0;
  bit m_io, m_vdp, m_rd, m_wr;
  int m_beats = 0;
  int m_pcnt = 0;
  int m_last_end = -1000;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_beats = 0; m_pcnt = 0; m_last_end = -1000;
      m_io = 0; m_vdp = 0; m_rd = 0; m_wr = 0;
    end else begin
      if (bus_ce) m_pcnt++;
      case (m_st)
        0: if (want_bus()) begin
             m_io  = io_now();
             m_vdp = io_now() && is_video(cpu_addr_lo);
             m_rd  = !cpu_rd_n;
             m_wr  = !cpu_wr_n;
             m_st  = 1;
           end
        1: if (bus_ce && (!m_vdp || (m_pcnt - m_last_end >= GAP))) begin
             m_st = 2; m_beats = 0;
           end
        2: if (bus_ce) begin
             m_beats++;
             if (m_beats == (m_io ? IO_W : MEM_W)) begin
               m_st = 3;
               if (m_vdp) m_last_end = m_pcnt;
             end
           end
        default: if (!want_bus()) m_st = 0;
      endcase
    end
  end

  // ---------------- per-cycle compare and port monitor ----------------
  int pid = 0, prev_pid = 0;
  bit prev_bce = 0, prev_idle = 1;
  int width = 0, last_width = 0, last_start = 0, last_end = 0;
  bit last_align = 1;
  int vdp_end_id = -1000, last_gap = 0;
  bit cur_vdp = 0;

  always @(negedge clk) begin
    bit bidle;
    int expv, actv;
    if (rst_n) begin
      expv = {!((m_st == 0 && want_bus()) || m_st == 1 || m_st == 2),
              !(m_st == 2 && m_io), !(m_st == 2 && !m_io),
              !(m_st == 2 && m_rd), !(m_st == 2 && m_wr)};
      actv = {cpu_wait_n, ext_iorq_n, ext_mreq_n, ext_rd_n, ext_wr_n};
      chk(actv == expv, "model R3 R4 R5 R6 R7 R12", actv, expv);
    end
    if (bus_ce) pid++;
    bidle = ext_iorq_n && ext_mreq_n;
    if (prev_idle && !bidle) begin
      width = 0;
      last_start = prev_pid;
      last_align = prev_bce;
      if (cur_vdp) last_gap = prev_pid - vdp_end_id;
    end
    if (!prev_idle && bidle) begin
      last_width = width;
      last_end = prev_pid;
      if (cur_vdp) vdp_end_id = prev_pid;
    end
    if (!bidle && bus_ce) width++;
    prev_idle = bidle;
    prev_bce = bus_ce;
    prev_pid = pid;
  end

  // ---------------- stimulus ----------------
  int req_pid = 0;

  task automatic access(input int kind, input logic [7:0] addr, input bit wr);
    bit dir_seen;
    @(posedge clk); #2;
    cpu_addr_lo  = addr;
    cpu_iorq_n   = !(kind == K_IO || kind == K_INTAK);
    cpu_mreq_n   = !(kind == K_XMEM || kind == K_IMEM);
    cpu_m1_n     = !(kind == K_INTAK);
    mem_internal = (kind == K_IMEM);
    cpu_rd_n     = (kind == K_INTAK) ? 1'b1 : wr;
    cpu_wr_n     = (kind == K_INTAK) ? 1'b1 : !wr;
    cur_vdp      = (kind == K_IO) && is_video(addr);
    req_pid      = pid;
    if (kind == K_IMEM || kind == K_INTAK) begin
      repeat (3) begin
        @(negedge clk);
        if (kind == K_IMEM)
          chk(cpu_wait_n && ext_iorq_n && ext_mreq_n, "R2 internal", {cpu_wait_n, ext_mreq_n}, 3);
        else
          chk(cpu_wait_n && ext_iorq_n && ext_mreq_n, "R10 intack", {cpu_wait_n, ext_iorq_n}, 3);
      end
    end else begin
      @(negedge clk);
      chk(!cpu_wait_n, "R3 wait at once", cpu_wait_n, 0);
      dir_seen = 0;
      for (int i = 0; i < 400; i++) begin
        if (!dir_seen && !(ext_iorq_n && ext_mreq_n)) begin
          dir_seen = 1;
          chk(ext_rd_n == wr && ext_wr_n == !wr, "R12 direction",
              {ext_rd_n, ext_wr_n}, {wr, !wr});
        end
        if (cpu_wait_n) break;
        @(negedge clk);
      end
      chk(cpu_wait_n && ext_iorq_n && ext_mreq_n, "R7 release", {cpu_wait_n, ext_iorq_n, ext_mreq_n}, 7);
    end
    @(posedge clk); #2;
    cpu_iorq_n = 1; cpu_mreq_n = 1; cpu_m1_n = 1; cpu_rd_n = 1; cpu_wr_n = 1;
    mem_internal = 0;
    if (kind == K_IO) begin
      chk(last_width == IO_W, "R5 io width", last_width, IO_W);
      chk(last_align, "R4 io align", last_align, 1);
    end else if (kind == K_XMEM) begin
      chk(last_width == MEM_W, "R6 mem width", last_width, MEM_W);
      chk(last_align, "R4 mem align", last_align, 1);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(cpu_wait_n && ext_iorq_n && ext_mreq_n && ext_rd_n && ext_wr_n, "R1 reset",
        {cpu_wait_n, ext_iorq_n, ext_mreq_n, ext_rd_n, ext_wr_n}, 31);

    access(K_IMEM, 8'h00, 0);
    access(K_IMEM, 8'h00, 1);

    // R11: first video access after reset is not held back
    access(K_IO, 8'h98, 1);
    chk(last_start - req_pid <= 2, "R11 first vdp", last_start - req_pid, 2);
    // R8: back-to-back video writes wait out the full gap
    access(K_IO, 8'h98, 1);
    chk(last_gap == GAP, "R8 back-to-back 98H", last_gap, GAP);
    access(K_IO, 8'h9B, 0);
    chk(last_gap == GAP, "R8 top port 9BH", last_gap, GAP);
    // R9: ports just outside the window go at once
    access(K_IO, 8'h9C, 1);
    chk(last_start - vdp_end_id <= 3, "R9 port 9CH", last_start - vdp_end_id, 3);
    access(K_IO, 8'h98, 0);
    access(K_IO, 8'h97, 0);
    chk(last_start - vdp_end_id <= 3, "R9 port 97H", last_start - vdp_end_id, 3);
    access(K_IO, 8'h9A, 1);
    chk(last_gap >= GAP, "R8 after other io", last_gap, GAP);

    for (int k = 0; k < RATIO; k++) begin
      idle(k);
      access(K_XMEM, 8'h00, k[0]);
      access(K_IO, 8'h20, !k[0]);
    end

    access(K_INTAK, 8'hFF, 0);
    access(K_IMEM, 8'h00, 0);

    idle((GAP + 8) * RATIO);
    access(K_IO, 8'h99, 1);
    chk(last_start - req_pid <= 2, "R11 after idle", last_start - req_pid, 2);
    access(K_IO, 8'h99, 1);
    chk(last_gap == GAP, "R8 again", last_gap, GAP);

    idle(4);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule